// File: doc/BRIEF.md
# Dual-Slope and Single-Slope 8-bit PWM Timer

This block is an 8-bit timer that drives one pulse-width-modulated output. A free-running prescaler divides the system clock to produce a timer tick. On each tick the 8-bit count moves one step. In single-slope (fast) operation the count climbs from 0 to 255 and wraps. In dual-slope (phase-correct) operation it climbs to 255 and then falls back to 0, which gives a waveform centred on the top of the count.

The compare value is written into a holding register. The timer copies it into the working compare register only on the tick at which the count is 255. This means every period runs with a single, consistent threshold. A 2-bit output mode turns the pin off, or makes it toggle, follow the compare result, or follow its complement. The compare values 0 and 255 give clean constant or single-tick outputs without any extra handling by the user.

Top module: `pwm8_dual`

## Requirements
- R1: `clk_sel` codes 0..6 select a divide ratio N of 1, 8, 32, 64, 128, 256 and 1024, and code 7 also selects 1024. The count steps once every N clocks. After reset is released, the first step happens on the N-th rising clock edge.
- R2: With `phase_mode`=0 the count runs 0,1,…,255,0, which is a period of 256 ticks.
- R3: With `phase_mode`=0 and `out_mode`=2, `wave` is high while count ≤ compare. A compare of 0 therefore gives one high tick per period, and 255 gives a constant high. `out_mode`=3 gives the complement.
- R4: With `phase_mode`=0 and `out_mode`=1, `wave` toggles on every tick at which count equals compare. The result is a 50% duty waveform with a period of 512 ticks.
- R5: With `phase_mode`=1 the count runs 0 up to 255 and back down to 1, then repeats. It is 255 for exactly one tick, and the period is 510 ticks.
- R6: With `phase_mode`=1 and `out_mode`=2, `wave` goes low when the rising count meets the compare and goes high when the falling count meets it. This gives 2·compare high ticks per period: compare 0 is constant low and 255 is constant high. `out_mode`=3 gives the complement, and `out_mode`=1 holds `wave` low.
- R7: A value written through `cmp_wr`/`cmp_wdata` takes effect only after the tick at which the count is 255. Until then the previous compare value still shapes `wave`.
- R8: `out_mode`=0 drives `wave` low in both modes.
- R9: `match` is high for exactly the clock cycles in which a tick occurs and the count equals the working compare value.
- R10: After reset, count is 0, the working compare value is 0 and the toggle state is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_mode | input | 1 | 0 = single-slope, 1 = dual-slope |
| out_mode | input | 2 | 0 off, 1 toggle, 2 normal, 3 inverted |
| clk_sel | input | 3 | Prescaler divide select |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| wave | output | 1 | PWM waveform |
| count | output | 8 | Current timer count |
| match | output | 1 | Compare-match pulse, one clock per matching tick |

## Verification
The bench measures the high time and the number of rising edges over one full period. It does this for compare values 0, 64, 100 and 255 in both slopes, at divide ratios 1 and 8. A design that mishandled the extremes would show a missing spike at 0, or a stray low tick at 255 in either slope. The bench also writes a new compare value in the middle of a period and checks that the old threshold still governs the remainder of that period. A design without the holding register would switch levels too early. Finally, it follows the count through the top and bottom turns and times the first prescaled step after reset, which catches a doubled 255, a period of 511 or 512, or an off-by-one divider.

// File: rtl/pwm8_dual.sv
module pwm8_dual #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_mode,
  input  logic [1:0] out_mode,
  input  logic [2:0] clk_sel,
  input  logic       cmp_wr,
  input  logic [7:0] cmp_wdata,
  output logic       wave,
  output logic [7:0] count,
  output logic       match
);
  localparam logic [7:0] TOP = 8'hFF;

  logic [PRE_W-1:0] pre, mask;
  logic [7:0] cnt, cmp_buf, cmp_act;
  logic up, tog, tick, lvl;

  always_comb begin
    case (clk_sel)
      3'd0:    mask = PRE_W'(0);
      3'd1:    mask = PRE_W'(7);
      3'd2:    mask = PRE_W'(31);
      3'd3:    mask = PRE_W'(63);
      3'd4:    mask = PRE_W'(127);
      3'd5:    mask = PRE_W'(255);
      default: mask = PRE_W'(1023);
    endcase
  end

  assign tick  = (pre & mask) == mask;
  assign count = cnt;
  assign match = tick && (cnt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_buf <= '0;
    else if (cmp_wr) cmp_buf <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      up      <= 1'b1;
      cmp_act <= '0;
      tog     <= 1'b0;
    end else if (tick) begin
      if (cnt == TOP) cmp_act <= cmp_buf;
      if (!phase_mode) begin
        cnt <= cnt + 8'd1;
        up  <= 1'b1;
        if (cnt == cmp_act) tog <= ~tog;
      end else if (up) begin
        cnt <= (cnt == TOP) ? 8'd254 : cnt + 8'd1;
        if (cnt >= 8'd254) up <= 1'b0;
      end else begin
        cnt <= (cnt == 8'd0) ? 8'd1 : cnt - 8'd1;
        if (cnt <= 8'd1) up <= 1'b1;
      end
    end
  end

  assign lvl = !phase_mode ? (cnt <= cmp_act)
             : (up ? (cnt < cmp_act) : (cnt <= cmp_act));

  always_comb begin
    case (out_mode)
      2'd0:    wave = 1'b0;
      2'd1:    wave = phase_mode ? 1'b0 : tog;
      2'd2:    wave = lvl;
      default: wave = ~lvl;
    endcase
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_fast_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !phase_mode && cnt == TOP) |=> (cnt == 8'd0));

  assert_top_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_mode && cnt == TOP) |=> (cnt == 8'd254 && !up));

  assert_up_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_mode && up && cnt < 8'd254) |=> (cnt == 8'($past(cnt) + 8'd1)));

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == TOP) |=> $stable(cmp_act));
endmodule

// File: tb/pwm8_dual_test.sv
module pwm8_dual_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, phase_mode = 0, cmp_wr = 0;
  logic [1:0] out_mode = 0;
  logic [2:0] clk_sel = 0;
  logic [7:0] cmp_wdata = 0;
  logic wave, match;
  logic [7:0] count;
  int checks = 0, failures = 0;
  bit done = 0;

  pwm8_dual uut (
    .clk(clk), .rst_n(rst_n), .phase_mode(phase_mode), .out_mode(out_mode),
    .clk_sel(clk_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .wave(wave), .count(count), .match(match)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_count(input int v);
    do @(negedge clk); while (count != 8'(v));
  endtask

  task automatic setup(input bit ph, input int om, input int sel, input int c);
    @(negedge clk);
    phase_mode = ph; out_mode = 2'(om); clk_sel = 3'(sel);
    cmp_wdata = 8'(c); cmp_wr = 1;
    @(negedge clk);
    cmp_wr = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; out_mode = 0; clk_sel = 1;
    repeat (3) @(negedge clk);
    check(count == 0, "R10 count after reset", count, 0);
    check(wave == 0, "R8 wave off in reset", wave, 0);
    rst_n = 1;
    begin
      int n = 0;
      while (count == 0 && n < 100) begin @(posedge clk); #1; n++; end
      check(n == 8, "R1 first step edge N=8", n, 8);
    end
  endtask

  task automatic t_gap(input int sel, input int n_exp);
    int g = 0;
    logic [7:0] last;
    @(negedge clk); phase_mode = 0; clk_sel = 3'(sel);
    last = count;
    do @(negedge clk); while (count == last);
    last = count;
    do begin @(negedge clk); g++; end while (count == last);
    check(g == n_exp, "R1 prescale gap", g, n_exp);
  endtask

  task automatic t_fast_seq;
    setup(0, 2, 0, 10);
    wait_count(254);
    @(negedge clk); check(count == 255, "R2 seq 255", count, 255);
    @(negedge clk); check(count == 0, "R2 wrap to 0", count, 0);
    @(negedge clk); check(count == 1, "R2 seq 1", count, 1);
  endtask

  task automatic t_phase_seq;
    setup(1, 2, 0, 10);
    wait_count(253);
    @(negedge clk); check(count == 254, "R5 up 254", count, 254);
    @(negedge clk); check(count == 255, "R5 top", count, 255);
    @(negedge clk); check(count == 254, "R5 single top tick", count, 254);
    @(negedge clk); check(count == 253, "R5 down 253", count, 253);
    wait_count(1);
    @(negedge clk); check(count == 0, "R5 bottom", count, 0);
    @(negedge clk); check(count == 1, "R5 turn up", count, 1);
    begin
      int p = 0;
      wait_count(255);
      do begin @(negedge clk); p++; end while (count != 255);
      check(p == 510, "R5 period", p, 510);
    end
  endtask

  task automatic t_duty(input string req, input bit ph, input int om, input int sel,
                        input int c, input int n, input int exp_hi, input int exp_rise);
    int per, hi = 0, rise = 0;
    logic prev;
    per = (ph ? 510 : (om == 1 ? 512 : 256)) * n;
    setup(ph, om, sel, c);
    repeat (2 * per) @(negedge clk);
    prev = wave;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      if (wave) hi++;
      if (wave && !prev) rise++;
      prev = wave;
    end
    check(hi == exp_hi, {req, " high time"}, hi, exp_hi);
    check(rise == exp_rise, {req, " rising edges"}, rise, exp_rise);
  endtask

  task automatic t_buffer;
    setup(0, 2, 0, 200);
    repeat (600) @(negedge clk);
    wait_count(50);
    cmp_wdata = 8'd10; cmp_wr = 1;
    @(negedge clk); cmp_wr = 0;
    wait_count(150);
    check(wave == 1, "R7 old compare still active", wave, 1);
    wait_count(20);
    check(wave == 0, "R7 new compare after top", wave, 0);
  endtask

  task automatic t_match;
    int m = 0;
    setup(0, 2, 0, 77);
    repeat (600) @(negedge clk);
    wait_count(77);
    check(match == 1, "R9 match at compare", match, 1);
    @(negedge clk);
    check(match == 0, "R9 no match after", match, 0);
    setup(0, 2, 1, 77);
    repeat (5000) @(negedge clk);
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (match) m++;
    end
    check(m == 1, "R9 one pulse per period N=8", m, 1);
  endtask

  initial begin
    t_reset;
    t_gap(2, 32);
    t_gap(7, 1024);
    t_gap(0, 1);
    t_fast_seq;
    t_phase_seq;
    t_duty("R3 fast c100 N8", 0, 2, 1, 100, 8, 808, 1);
    t_duty("R3 fast c0", 0, 2, 0, 0, 1, 1, 1);
    t_duty("R3 fast c255", 0, 2, 0, 255, 1, 256, 0);
    t_duty("R3 fast inv c100", 0, 3, 0, 100, 1, 155, 1);
    t_duty("R4 fast toggle", 0, 1, 0, 30, 1, 256, 1);
    t_duty("R8 fast off", 0, 0, 0, 100, 1, 0, 0);
    t_duty("R6 phase c64", 1, 2, 0, 64, 1, 128, 1);
    t_duty("R6 phase c64 N8", 1, 2, 1, 64, 8, 1024, 1);
    t_duty("R6 phase c0", 1, 2, 0, 0, 1, 0, 0);
    t_duty("R6 phase c255", 1, 2, 0, 255, 1, 510, 0);
    t_duty("R6 phase inv c64", 1, 3, 0, 64, 1, 382, 1);
    t_duty("R6 phase mode1 low", 1, 1, 0, 64, 1, 0, 0);
    t_duty("R8 phase off", 1, 0, 0, 64, 1, 0, 0);
    t_buffer;
    t_match;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule